// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master for a single slave. A host reaches it through a small register bus that uses a strobe and an acknowledge, with an 8-bit address and 8-bit data. The host first sets the clock divider and the control byte. It then writes a byte to the transmit register, which starts one 8-bit full-duplex exchange. The host polls the status register until the exchange has finished and reads the byte that came back. Status flags are cleared by writing a one to their bit.

The control register enables the core. It also decides whether chip select stays low between bytes, so software can chain several bytes into one transaction. A common use sends a command byte and then a dummy 0xFF, and joins the two returned bytes into a 16-bit word with the first byte as the upper half. Frames are shifted MSB first in SPI mode 0. The SCLK rate is the system clock divided by 2×(N+1), where N is the prescale register.

Top module: `spi_regmaster`

## Requirements
- R1: After `bus_stb` rises, `bus_ack` is high for exactly one cycle, one cycle later. It does not rise again until `bus_stb` has been low for at least one cycle. Read data on `bus_rdata` is valid while `bus_ack` is high. `bus_rw`=1 is a write and `bus_rw`=0 is a read.
- R2: After reset the following hold:
  - `spi_cs_n`=1 and `spi_sclk`=0.
  - Status (0x06) reads 0x10.
  - Control (0x0A) reads 0x00.
  - Prescale (0x0B) reads 0x00.
- R3: In control (0x0A), bit 7 enables the core and bit 6 holds chip select.
  - `spi_cs_n` is low exactly when both bits are set, so 0xC0 drives it low and 0x80 releases it.
  - Control reads back bits 7:6, with the other bits as zero.
- R4: A write to 0x0D while the core is enabled and idle loads the byte, starts an exchange and clears transmit-ready. While the core is disabled, such a write has no effect: SCLK does not toggle and status stays unchanged.
- R5: The exchange is SPI mode 0, MSB first.
  - SCLK idles low.
  - MOSI is stable on every rising SCLK edge and changes only after falling edges.
  - MISO is sampled on rising edges.
  - The 8 received bits, first bit as MSB, are read at 0x0E.
- R6: With prescale value N, SCLK is high for N+1 clocks, and its period is 2×(N+1) clocks.
- R7: When the eighth bit completes, both receive-ready (status bit 3) and transmit-ready (status bit 4) become set.
- R8: In a status write, each one bit clears its flag: 0x08 clears receive-ready and 0x10 clears transmit-ready. Zero bits leave the flags unchanged.
- R9: Reads of any address other than 0x06, 0x0A, 0x0B and 0x0E return 0x00. Writes to any address other than 0x06, 0x0A, 0x0B and 0x0D are ignored.
- R10: While control holds chip select, consecutive exchanges keep `spi_cs_n` low the whole time.
- R11: A write to 0x0D during an exchange is ignored. The byte in flight is shifted out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Access strobe, held until acknowledged |
| bus_rw | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle access acknowledge |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification

The bench targets these corner cases:

- **Strobe held high.** The strobe stays high for several cycles. A design that acknowledged level instead of edge would show more than one acknowledge pulse.
- **Clock divider.** Divider values are drawn at random, and the SCLK high time and period are measured. An off-by-one in the divider shows up directly in those counts.
- **Transmit write during an exchange.** A second transmit write arrives while a byte is in flight. A design that reloads its shift register would put the second byte on MOSI.
- **Transmit write while disabled.** A transmit write arrives with the core disabled. A design that starts anyway would toggle SCLK.
- **Partial status writes.** Status writes with zero bits, and with each bit on its own, expose a plain write where a write-one-to-clear is needed.
- **Two-byte held transfer.** A chip-select monitor catches any release of chip select between the two bytes.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_STATUS = 8'h06;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h0A;
    localparam logic [ADDR_W-1:0] A_PRESC  = 8'h0B;
    localparam logic [ADDR_W-1:0] A_TXD    = 8'h0D;
    localparam logic [ADDR_W-1:0] A_RXD    = 8'h0E;

    localparam int B_TXRDY = 4;
    localparam int B_RXRDY = 3;
    localparam int B_EN    = 7;
    localparam int B_HOLD  = 6;

    typedef struct packed {
        logic en;
        logic hold;
    } ctl_t;

    typedef struct packed {
        logic txrdy;
        logic rxrdy;
    } flags_t;

    function automatic logic [DATA_W-1:0] status_byte(flags_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_TXRDY] = f.txrdy;
        v[B_RXRDY] = f.rxrdy;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_byte(ctl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_EN]   = c.en;
        v[B_HOLD] = c.hold;
        return v;
    endfunction
endpackage

// File: rtl/spi_regmaster_bus.sv
module spi_regmaster_bus (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic access,
    output logic ack
);
    logic served;

    assign access = stb & ~served;

    always_ff @(posedge clk) begin
        if (rst) begin
            served <= 1'b0;
            ack    <= 1'b0;
        end else begin
            ack <= access;
            if (access)
                served <= 1'b1;
            else if (!stb)
                served <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_regmaster_shift.sv
module spi_regmaster_shift #(
    parameter int FRAME_BITS = 8,
    parameter int PRE_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_byte,
    input  logic [PRE_W-1:0]      half_cnt,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_byte
);
    localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    logic [PRE_W-1:0]      cnt;
    logic [BIT_W-1:0]      bitn;
    logic [FRAME_BITS-1:0] sh_tx;
    logic [FRAME_BITS-1:0] sh_rx;

    assign mosi    = sh_tx[FRAME_BITS-1];
    assign rx_byte = sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk  <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            bitn  <= '0;
            sh_tx <= '0;
            sh_rx <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                sclk  <= 1'b0;
                cnt   <= '0;
                bitn  <= '0;
                sh_tx <= tx_byte;
            end else if (busy) begin
                if (cnt == half_cnt) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        sh_rx <= {sh_rx[FRAME_BITS-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == LAST_BIT) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            sh_tx <= {sh_tx[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_regmaster_pkg::*;
#(
    parameter int PRE_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_stb,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic              access;
    logic              wr_acc;
    logic              rd_acc;
    ctl_t              ctl;
    flags_t            flg;
    logic [PRE_W-1:0]  presc;
    logic [DATA_W-1:0] rx_hold;
    logic [DATA_W-1:0] eng_rx;
    logic              eng_busy;
    logic              eng_done;
    logic              start;
    logic              ctl_en;
    logic              txrdy;

    spi_regmaster_bus u_bus (
        .clk    (clk),
        .rst    (rst),
        .stb    (bus_stb),
        .access (access),
        .ack    (bus_ack)
    );

    assign wr_acc = access & bus_rw;
    assign rd_acc = access & ~bus_rw;
    assign start  = wr_acc && (bus_addr == A_TXD) && ctl.en && !eng_busy;

    spi_regmaster_shift #(
        .FRAME_BITS (DATA_W),
        .PRE_W      (PRE_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tx_byte  (bus_wdata),
        .half_cnt (presc),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_byte  (eng_rx)
    );

    assign spi_cs_n = ~(ctl.en & ctl.hold);
    assign ctl_en   = ctl.en;
    assign txrdy    = flg.txrdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            presc     <= '0;
            flg.txrdy <= 1'b1;
            flg.rxrdy <= 1'b0;
            rx_hold   <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_acc) begin
                case (bus_addr)
                    A_CTRL: begin
                        ctl.en   <= bus_wdata[B_EN];
                        ctl.hold <= bus_wdata[B_HOLD];
                    end
                    A_PRESC: presc <= bus_wdata[PRE_W-1:0];
                    A_STATUS: begin
                        if (bus_wdata[B_TXRDY]) flg.txrdy <= 1'b0;
                        if (bus_wdata[B_RXRDY]) flg.rxrdy <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (start)
                flg.txrdy <= 1'b0;
            if (eng_done) begin
                flg.txrdy <= 1'b1;
                flg.rxrdy <= 1'b1;
                rx_hold   <= eng_rx;
            end
            if (rd_acc) begin
                case (bus_addr)
                    A_STATUS: bus_rdata <= status_byte(flg);
                    A_CTRL:   bus_rdata <= ctl_byte(ctl);
                    A_PRESC:  bus_rdata <= DATA_W'(presc);
                    A_RXD:    bus_rdata <= rx_hold;
                    default:  bus_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
    input logic clk,
    input logic rst,
    input logic bus_stb,
    input logic bus_ack,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic eng_busy,
    input logic txrdy,
    input logic ctl_en
);
    p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    p_ack_after_stb_r1: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(bus_stb));

    p_cs_off_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> spi_cs_n);

    p_txrdy_low_busy_r4: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !txrdy);

    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !spi_sclk);
endmodule

bind spi_regmaster spi_regmaster_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_stb  (bus_stb),
    .bus_ack  (bus_ack),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .eng_busy (eng_busy),
    .txrdy    (txrdy),
    .ctl_en   (ctl_en)
);

// File: tb/spi_regmaster_tb.sv
`timescale 1ns/1ps
module spi_regmaster_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_stb = 1'b0;
    logic       bus_rw = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_ack;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;
    logic       spi_cs_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spi_regmaster dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_stb   (bus_stb),
        .bus_rw    (bus_rw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    logic [7:0] mon_sh = 8'h00;
    int         mon_cnt = 0;
    logic [7:0] slave_sh = 8'h00;
    realtime    t_rise = 0.0;
    realtime    t_prev = 0.0;
    int         hi_cyc = 0;
    int         per_cyc = 0;
    int         cs_rise_cnt = 0;

    always @(posedge spi_sclk) begin
        mon_sh  = {mon_sh[6:0], spi_mosi};
        mon_cnt = mon_cnt + 1;
        t_prev  = t_rise;
        t_rise  = $realtime;
        per_cyc = int'((t_rise - t_prev) / 4.0);
    end

    always @(negedge spi_sclk) begin
        hi_cyc   = int'(($realtime - t_rise) / 4.0);
        slave_sh = {slave_sh[6:0], 1'b0};
        spi_miso = slave_sh[7];
    end

    always @(posedge spi_cs_n) cs_rise_cnt = cs_rise_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rw = 1'b1; bus_addr = a; bus_wdata = d; bus_stb = 1'b1;
        do @(negedge clk); while (!bus_ack);
        bus_stb = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rw = 1'b0; bus_addr = a; bus_stb = 1'b1;
        do @(negedge clk); while (!bus_ack);
        d = bus_rdata;
        bus_stb = 1'b0;
    endtask

    task automatic wait_txrdy();
        logic [7:0] s;
        for (int i = 0; i < 300; i++) begin
            bus_read(8'h06, s);
            if (s[4]) break;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sl,
                        output logic [7:0] got_mosi, output logic [7:0] got_rx);
        slave_sh = sl;
        spi_miso = sl[7];
        mon_cnt  = 0;
        bus_write(8'h0D, tx);
        wait_txrdy();
        got_mosi = mon_sh;
        bus_read(8'h0E, got_rx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] r, m, x, r1, r2;
        int         n, cnt, first;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2 reset state
        check("R2 cs_n", int'(spi_cs_n), 1);
        check("R2 sclk", int'(spi_sclk), 0);
        bus_read(8'h06, r); check("R2 status", r, 8'h10);
        bus_read(8'h0A, r); check("R2 control", r, 8'h00);
        bus_read(8'h0B, r); check("R2 prescale", r, 8'h00);

        // R1 strobe held high: one ack, first cycle after raise
        @(negedge clk);
        bus_rw = 1'b1; bus_addr = 8'h33; bus_wdata = 8'hAA; bus_stb = 1'b1;
        cnt = 0; first = -1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_ack) begin cnt++; if (first < 0) first = i; end
        end
        bus_stb = 1'b0;
        check("R1 ack count", cnt, 1);
        check("R1 ack position", first, 0);

        // R9 unmapped
        bus_read(8'h33, r); check("R9 unmapped read 0x33", r, 8'h00);
        bus_read(8'h0D, r); check("R9 unmapped read 0x0D", r, 8'h00);
        bus_write(8'h0C, 8'hFF);
        bus_read(8'h0A, r); check("R9 write ignored ctrl", r, 8'h00);
        bus_read(8'h06, r); check("R9 write ignored status", r, 8'h10);

        // R4 disabled core ignores transmit write
        mon_cnt = 0;
        bus_write(8'h0D, 8'h5A);
        repeat (40) @(negedge clk);
        check("R4 no sclk when disabled", mon_cnt, 0);
        bus_read(8'h06, r); check("R4 status unchanged", r, 8'h10);

        // R3 control
        bus_write(8'h0A, 8'h80);
        check("R3 cs_n released 0x80", int'(spi_cs_n), 1);
        bus_read(8'h0A, r); check("R3 ctrl readback", r, 8'h80);
        bus_write(8'h0A, 8'hFF);
        bus_read(8'h0A, r); check("R3 ctrl readback masked", r, 8'hC0);
        check("R3 cs_n low 0xC0", int'(spi_cs_n), 0);
        bus_write(8'h0A, 8'h80);

        // R8 write-one-to-clear after one exchange
        xfer(8'h96, 8'h69, m, x);
        bus_read(8'h06, r); check("R7 both flags", r, 8'h18);
        bus_write(8'h06, 8'h00);
        bus_read(8'h06, r); check("R8 zero write keeps", r, 8'h18);
        bus_write(8'h06, 8'h08);
        bus_read(8'h06, r); check("R8 clear rx only", r, 8'h10);
        bus_write(8'h06, 8'h10);
        bus_read(8'h06, r); check("R8 clear tx", r, 8'h00);

        // R11 transmit write during exchange
        bus_write(8'h0B, 8'h03);
        slave_sh = 8'h0F; spi_miso = 1'b0; mon_cnt = 0;
        bus_write(8'h0D, 8'hC3);
        bus_write(8'h0D, 8'h00);
        wait_txrdy();
        check("R11 byte unchanged", mon_sh, 8'hC3);
        check("R11 eight bits", mon_cnt, 8);
        bus_read(8'h0E, r); check("R11 rx", r, 8'h0F);

        // Random exchanges: R5 R6 R7 R8
        for (int k = 0; k < 10; k++) begin
            logic [7:0] tx, sl;
            n  = int'($urandom % 4);
            tx = 8'($urandom);
            sl = 8'($urandom);
            if (k == 0) begin tx = 8'h80; sl = 8'h01; end
            if (k == 1) begin tx = 8'h01; sl = 8'hFE; end
            bus_write(8'h0B, 8'(n));
            bus_read(8'h0B, r); check("R6 prescale readback", r, n);
            xfer(tx, sl, m, x);
            check("R5 mosi byte", m, tx);
            check("R5 rx byte", x, sl);
            check("R6 high time", hi_cyc, n + 1);
            check("R6 period", per_cyc, 2 * (n + 1));
            bus_read(8'h06, r); check("R7 flags after byte", r, 8'h18);
            bus_write(8'h06, 8'h18);
            bus_read(8'h06, r); check("R8 cleared both", r, 8'h00);
        end

        // R10 two-byte held transfer
        bus_write(8'h0B, 8'h01);
        bus_write(8'h0A, 8'hC0);
        check("R10 cs_n low", int'(spi_cs_n), 0);
        cs_rise_cnt = 0;
        xfer(8'h35, 8'hA5, m, r1);
        xfer(8'hFF, 8'h3C, m, r2);
        check("R10 cs held", cs_rise_cnt, 0);
        check("R10 word", int'({r1, r2}), 16'hA53C);
        check("R10 dummy byte", m, 8'hFF);
        bus_write(8'h0A, 8'h80);
        check("R10 cs released", int'(spi_cs_n), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule